// File: doc/BRIEF.md
# Stream Byte-Inverting Checksum Sink

This block is the receiving end of a 32-bit byte stream, typically fed by a memory-to-stream DMA engine. Each beat offers four byte lanes. A per-lane keep bit marks which lanes carry payload. Every kept byte is complemented bitwise, and the complements are added modulo 256 over all beats of a packet. A packet ends with the beat that carries the last flag. The 8-bit total appears on an output port once the packet closes. It stays there until the next packet closes.

The same total can be read through a small read-only register port, so that software can fetch the checksum after a transfer. The sink never applies backpressure, because a stalled sink would hang the upstream DMA. The strobe lanes are accepted for interface compatibility and have no effect. Short final beats are expected to be packed toward the least significant lanes.

Top module: `csum_sink`

## Requirements
- R1: `s_ready` is 0 while `rst` is high and 1 in every cycle while `rst` is low.
- R2: A synchronous reset drives `sum_o` to 8'h00 and makes the next accepted beat the first of a packet.
- R3: A byte in lane i (bits 8i+7..8i of `s_data`) adds its bitwise complement to the packet total when `s_keep[i]` is 1. For example, eight zero bytes give 8'hF8.
- R4: A lane whose `s_keep` bit is 0 adds nothing, whatever its data. Six zero bytes followed by two masked nonzero bytes give 8'hFA.
- R5: `s_strb` has no effect on the total.
- R6: The total is taken modulo 256 over all beats of a packet. It appears on `sum_o` in the cycle after the edge that accepts the beat with `s_last` = 1.
- R7: `sum_o` keeps its value through every cycle in which no beat with `s_last` = 1 is accepted. This includes the non-last beats of the following packet.
- R8: The first beat accepted after a `s_last` beat starts a new total from zero. Nothing carries over from the previous packet.
- R9: A cycle with `s_valid` = 0 transfers nothing, whatever `s_data`, `s_keep` and `s_last` hold.
- R10: `rd_data` equals {24'b0, `sum_o`} when `rd_addr` is 0, and it is 0 at any other address.
- R11: A packet made of a single beat with `s_last` = 1 yields the total of that beat alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Beat offered |
| s_ready | output | 1 | Sink ready, high whenever out of reset |
| s_data | input | 32 | Four byte lanes of payload |
| s_keep | input | 4 | Per-lane payload qualifier |
| s_strb | input | 4 | Per-lane strobe, ignored |
| s_last | input | 1 | Final beat of a packet |
| sum_o | output | 8 | Checksum of the most recently completed packet |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data |

## Verification
The bench builds the block with its default parameters: four byte lanes, an 8-bit total and a 4-bit register address. With four lanes, every LSB-packed keep pattern can be covered, as well as fully masked lanes and a forty-beat packet whose total wraps modulo 256 many times. With a 4-bit address, both the result register and several empty offsets can be reached. Idle gaps are driven with garbage data, and the output is checked mid-packet, to show that accumulation and the held result stay independent.

// File: rtl/csum_pkg.sv
package csum_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Position of the next accepted beat within its packet
    typedef enum logic {
        POS_MID   = 1'b0,
        POS_START = 1'b1
    } pkt_pos_e;

    // One lane's contribution: complemented byte when kept, else nothing
    function automatic byte_t lane_term(input byte_t b, input logic kept);
        return kept ? ~b : '0;
    endfunction

endpackage

// File: rtl/csum_lane_fold.sv
module csum_lane_fold
    import csum_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*BYTE_W-1:0] data,
    input  logic [LANES-1:0]        keep,
    output byte_t                   beat_sum
);

    byte_t terms [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign terms[g] = lane_term(data[g*BYTE_W +: BYTE_W], keep[g]);
    end

    always_comb begin
        beat_sum = '0;
        for (int i = 0; i < LANES; i++) begin
            beat_sum = beat_sum + terms[i];
        end
    end

endmodule

// File: rtl/csum_accum.sv
module csum_accum
    import csum_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  take,
    input  logic  last,
    input  byte_t beat_sum,
    output byte_t sum_q
);

    byte_t    acc_q;
    byte_t    acc_nxt;
    pkt_pos_e pos_q;

    always_comb begin
        acc_nxt = ((pos_q == POS_START) ? byte_t'(0) : acc_q) + beat_sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            sum_q <= '0;
            pos_q <= POS_START;
        end else if (take) begin
            acc_q <= acc_nxt;
            pos_q <= last ? POS_START : POS_MID;
            if (last) begin
                sum_q <= acc_nxt;
            end
        end
    end

endmodule

// File: rtl/csum_regport.sv
module csum_regport
    import csum_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int RD_W   = 32
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  byte_t             value,
    output logic [RD_W-1:0]   rd_data
);

    localparam int PAD_W = RD_W - BYTE_W;

    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) begin
            rd_data = {{PAD_W{1'b0}}, value};
        end
    end

endmodule

// File: rtl/csum_sink.sv
module csum_sink
    import csum_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 4,
    parameter int RD_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    s_valid,
    output logic                    s_ready,
    input  logic [LANES*BYTE_W-1:0] s_data,
    input  logic [LANES-1:0]        s_keep,
    input  logic [LANES-1:0]        s_strb,
    input  logic                    s_last,
    output logic [BYTE_W-1:0]       sum_o,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [RD_W-1:0]         rd_data
);

    byte_t beat_sum;
    byte_t sum_q;
    logic  take;
    logic  unused_strb;

    assign s_ready     = ~rst;
    assign take        = s_valid & s_ready;
    assign unused_strb = ^s_strb;

    csum_lane_fold #(.LANES(LANES)) u_fold (
        .data     (s_data),
        .keep     (s_keep),
        .beat_sum (beat_sum)
    );

    csum_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .last     (s_last),
        .beat_sum (beat_sum),
        .sum_q    (sum_q)
    );

    csum_regport #(.ADDR_W(ADDR_W), .RD_W(RD_W)) u_reg (
        .rd_addr (rd_addr),
        .value   (sum_q),
        .rd_data (rd_data)
    );

    assign sum_o = sum_q;

endmodule

// File: rtl/csum_sink_chk.sv
module csum_sink_chk #(
    parameter int ADDR_W = 4,
    parameter int RD_W   = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              s_valid,
    input logic              s_ready,
    input logic              s_last,
    input logic [7:0]        sum_o,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [RD_W-1:0]   rd_data
);

    AST_READY_WHEN_RUNNING: assert property (@(posedge clk) disable iff (rst) s_ready == 1'b1); // R1

    AST_RESET_CLEARS_SUM: assert property (@(posedge clk) $past(rst) |-> sum_o == 8'h00); // R2

    AST_HOLD_WITHOUT_LAST: assert property (@(posedge clk) disable iff (rst)
        !(s_valid && s_ready && s_last) |=> $stable(sum_o)); // R7

    AST_REG_MIRRORS_SUM: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == '0) |-> rd_data == {{(RD_W-8){1'b0}}, sum_o}); // R10

    AST_REG_EMPTY_ELSEWHERE: assert property (@(posedge clk) disable iff (rst)
        (rd_addr != '0) |-> rd_data == '0); // R10

endmodule

bind csum_sink csum_sink_chk #(.ADDR_W(ADDR_W), .RD_W(RD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_last  (s_last),
    .sum_o   (sum_o),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/csum_sink_tb.sv
`timescale 1ns/1ps
module csum_sink_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_data = '0;
    logic [3:0]  s_keep = '0;
    logic [3:0]  s_strb = '0;
    logic        s_last = 1'b0;
    logic [7:0]  sum_o;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int   n_vec  = 0;
    int   n_fail = 0;
    logic [7:0] exp_acc = '0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    csum_sink u_dut (
        .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_keep(s_keep), .s_strb(s_strb), .s_last(s_last),
        .sum_o(sum_o), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] model_beat(input logic [31:0] d, input logic [3:0] k);
        logic [7:0] s = '0;
        for (int i = 0; i < 4; i++) begin
            if (k[i]) s = s + ~d[i*8 +: 8];
        end
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: called just after a falling edge; returns just after the next falling edge
    task automatic beat(input logic [31:0] d, input logic [3:0] k,
                        input logic [3:0] st, input logic l, input string req);
        s_valid = 1'b1; s_data = d; s_keep = k; s_strb = st; s_last = l;
        exp_acc = exp_acc + model_beat(d, k);
        if (l) begin
            exp_q.push_back(exp_acc);
            tag_q.push_back(req);
            exp_acc = '0;
        end
        @(negedge clk);
        s_valid = 1'b0; s_data = 32'hDEAD_BEEF; s_keep = 4'hF; s_last = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: on every accepted closing beat, compare the next output against the queue
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && s_valid && s_ready && s_last) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check("R6 unexpected result", {24'b0, sum_o}, 32'hFFFF_FFFF);
                end else begin
                    check(tag_q.pop_front(), {24'b0, sum_o}, {24'b0, exp_q.pop_front()});
                end
            end
        end
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        idle(2);
        check("R1 ready low in reset", {31'b0, s_ready}, 32'd0);
        rst = 1'b0;
        idle(1);
        check("R2 reset sum", {24'b0, sum_o}, 32'd0);
        check("R1 ready high", {31'b0, s_ready}, 32'd1);

        // R3: eight zero bytes -> F8
        beat(32'h0, 4'hF, 4'hF, 1'b0, "R3");
        beat(32'h0, 4'hF, 4'hF, 1'b1, "R3 eight zero bytes");
        idle(1);
        check("R3 literal F8", {24'b0, sum_o}, 32'h0000_00F8);

        // R4: six zero bytes, two masked nonzero bytes -> FA
        beat(32'h0, 4'hF, 4'hF, 1'b0, "R4");
        beat(32'h1010_0000, 4'h3, 4'h3, 1'b1, "R4 masked lanes");
        idle(1);
        check("R4 literal FA", {24'b0, sum_o}, 32'h0000_00FA);

        // R5: strobe patterns differ, same data and keep
        beat(32'h1234_5678, 4'hF, 4'h0, 1'b1, "R5 strb zero");
        beat(32'h1234_5678, 4'hF, 4'h5, 1'b1, "R5 strb mixed");

        // R7: mid-packet beat leaves the held result alone
        beat(32'hA5A5_0F0F, 4'hF, 4'hF, 1'b0, "R7");
        check("R7 hold mid-packet", {24'b0, sum_o}, {24'b0, model_beat(32'h1234_5678, 4'hF)});
        // R9: idle cycles with garbage do not count
        idle(3);
        check("R9 hold in gap", {24'b0, sum_o}, {24'b0, model_beat(32'h1234_5678, 4'hF)});
        beat(32'h0000_00C3, 4'h1, 4'h1, 1'b1, "R9 gap packet");

        // R8 / R11: single-beat packets start fresh
        beat(32'h0000_00FF, 4'h1, 4'h1, 1'b1, "R11 single beat");
        beat(32'h0102_0304, 4'h7, 4'h7, 1'b1, "R8 fresh start");

        // R6: long packet, modulo-256 wrap
        for (int i = 0; i < 40; i++) begin
            beat(32'h0 + i * 32'h0107_0B0D, 4'hF, 4'hF, i == 39, "R6 long packet");
        end
        beat(32'h8000_0001, 4'hF, 4'hA, 1'b1, "R6 single");

        // R10: register port
        idle(1);
        rd_addr = 4'd0;
        #1;
        check("R10 offset 0", rd_data, {24'b0, sum_o});
        rd_addr = 4'd4;
        #1;
        check("R10 offset 4", rd_data, 32'd0);
        rd_addr = 4'd15;
        #1;
        check("R10 offset 15", rd_data, 32'd0);

        // R2: reset mid-packet clears and restarts
        beat(32'h0, 4'hF, 4'hF, 1'b0, "R2");
        rst = 1'b1;
        exp_acc = '0;
        idle(1);
        rst = 1'b0;
        idle(1);
        check("R2 reset clears", {24'b0, sum_o}, 32'd0);
        beat(32'h0000_0000, 4'h1, 4'h1, 1'b1, "R2 restart after reset");
        idle(2);

        check("R6 queue drained", exp_q.size(), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule